// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs an analog-to-digital conversion built from a single-bit delta-sigma DAC and an external comparator. It drives the DAC input word and compares it against the analog input by reading the comparator output, which is high when the input is above the DAC reference. It decides one bit per trial in a binary search that begins at mid-scale.

Each trial is held long enough for the DAC bitstream to average and for the external RC filter to settle. The hold time is 2^N clocks multiplied by a run-time settle multiplier plus one, where N is the DAC word width. After N trials, the upper N-1 bits of the decided word form the result. The result is offered to a downstream FIFO with a one-cycle push. A pulse at the start of every conversion can drive an external sample-and-hold. Conversions repeat back to back for as long as the enable input stays high.

Top module: `dsadc_sar_seq`

## Requirements
- R1: While reset is low at a clock edge, the block clears its state. After that edge, `dac_word` is 0, and `sample_hold` and `res_push` are 0.
- R2: A conversion starts at the first clock edge where `conv_en` is 1 and the block is idle. In the first cycle of the conversion, `sample_hold` is 1 for exactly one cycle and `dac_word` holds mid-scale, which is only the MSB set.
- R3: Each trial lasts 2^DAC_W × (settle + 1) clocks, and a conversion is DAC_W trials. The push comes DAC_W × trial-length cycles after the conversion's `sample_hold` cycle. While enabled, the next conversion starts in that same cycle, so `sample_hold` is also 1.
- R4: On the last clock of a trial, the block reads the comparator after a two-flop synchroniser. If it reads 1, the trial bit stays set; if 0, the bit is cleared. The next lower bit is then set for the next trial. So with input code v, the first trial is followed by a word of 24 if v ≥ 16, or 8 otherwise, when DAC_W=5.
- R5: When all bits are decided, `res_data` takes the upper DAC_W-1 bits of the decided word, and `res_push` pulses for one cycle. For a comparator that is high when v ≥ `dac_word`, the result is v >> 1.
- R6: If `fifo_full` is 1 on the last clock of a conversion, there is no push and `res_data` keeps its previous value.
- R7: When `conv_en` is 0 at an edge, the block is idle after that edge. Any conversion in progress is abandoned: `dac_word` is 0 and there is no push.
- R8: The settle multiplier is captured at the start of each conversion. Changing it during a conversion does not alter that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_en | input | 1 | Conversion enable |
| settle_mult | input | SET_W | Settle multiplier; each trial is multiplied by this value plus one |
| cmp_above | input | 1 | Comparator output, asynchronous, high when the input is above the reference |
| fifo_full | input | 1 | Downstream FIFO full |
| dac_word | output | DAC_W | DAC input word |
| sample_hold | output | 1 | One-cycle pulse at the start of each conversion |
| res_data | output | DAC_W-1 | Latest pushed result |
| res_push | output | 1 | One-cycle write strobe for the FIFO |

## Verification
The hardest cases are the timing edges. One is a full FIFO at the exact clock that ends a conversion. Another is enable falling in the middle of a trial. A third is a settle multiplier that changes after capture. The bench counts cycles from each `sample_hold` pulse and places the disturbance inside a known trial. It then watches the ports across a whole conversion window. The comparator is modelled from the DAC word itself, so every trial path of the search is exercised by choosing input codes across the range.

// File: rtl/dsadc_seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsadc_seq_pkg;

    // Top-level sequencing state.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

    // Minimum number of synchroniser flops for the comparator input.
    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage : dsadc_seq_pkg

// File: rtl/dsadc_sync.sv
// Module: dsadc_sync
// Purpose: brings the asynchronous comparator output into the clock domain
//          through a chain of flops.
// Assumes: STAGES >= 2; the input holds steady for several clocks around
//          each decision, so a single metastable sample is harmless.
module dsadc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= dsadc_seq_pkg::MIN_SYNC_STAGES); // R4
    end

endmodule : dsadc_sync

// File: rtl/dsadc_dwell.sv
// Module: dsadc_dwell
// Purpose: times one trial. It counts 2^DAC_W clocks for bitstream
//          averaging, repeated (mult+1) times for filter settling, and
//          flags the last clock of the trial.
// Assumes: load restarts the count and captures the multiplier; clr wins
//          over load; run is high only while a conversion is active.
module dsadc_dwell #(
    parameter int unsigned DAC_W = 9,
    parameter int unsigned SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             run,
    input  logic [SET_W-1:0] mult,
    output logic             last
);

    logic [DAC_W-1:0] sub_cnt;
    logic [SET_W-1:0] mul_cnt;
    logic [SET_W-1:0] mult_q;
    logic             sub_wrap;

    assign sub_wrap = &sub_cnt;
    assign last     = run && sub_wrap && (mul_cnt == mult_q);

    // Count clocks within the trial; restart on load, clear, or trial end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sub_cnt <= '0;
            mul_cnt <= '0;
        end else if (load || last) begin
            sub_cnt <= '0;
            mul_cnt <= '0;
        end else if (run) begin
            sub_cnt <= sub_cnt + 1'b1;
            if (sub_wrap) mul_cnt <= mul_cnt + 1'b1;
        end
    end

    // Capture the settle multiplier once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)    mult_q <= '0;
        else if (load) mult_q <= mult;
    end

    AST_MUL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mul_cnt <= mult_q); // R3
    AST_MULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mult_q)); // R8

endmodule : dsadc_dwell

// File: rtl/dsadc_sar_reg.sv
// Module: dsadc_sar_reg
// Purpose: holds the trial word and a one-hot pointer to the bit under
//          test, and applies each comparator decision.
// Assumes: clr beats load, and load beats step; keep is the synchronised
//          comparator value sampled on the step clock.
module dsadc_sar_reg #(
    parameter int unsigned DAC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic             keep,
    output logic [DAC_W-1:0] word,
    output logic             last_bit,
    output logic [DAC_W-2:0] result
);

    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    logic [DAC_W-1:0] mask;
    logic [DAC_W-1:0] decided;

    // Apply the decision to the bit under test.
    always_comb begin
        decided = keep ? word : (word & ~mask);
    end

    assign last_bit = mask[0];
    assign result   = decided[DAC_W-1:1];

    // Trial register and bit pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
            mask <= '0;
        end else if (load) begin
            word <= MID;
            mask <= MID;
        end else if (step) begin
            word <= decided | (mask >> 1);
            mask <= mask >> 1;
        end
    end

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask)); // R4
    AST_WORD_ABOVE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !clr && !last_bit) |=> (word & (mask - 1'b1)) == '0); // R4

endmodule : dsadc_sar_reg

// File: rtl/dsadc_sar_seq.sv
// Module: dsadc_sar_seq (top)
// Purpose: sequences successive-approximation conversions for a delta-sigma
//          DAC and an external comparator. It starts each conversion with a
//          sample pulse and pushes each result into a downstream FIFO.
// Assumes: DAC_W >= 2; SET_W is between 4 and 8; the FIFO accepts a push
//          in any cycle where it is not full.
module dsadc_sar_seq
    import dsadc_seq_pkg::*;
#(
    parameter int unsigned DAC_W       = 9,
    parameter int unsigned SET_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_en,
    input  logic [SET_W-1:0] settle_mult,
    input  logic             cmp_above,
    input  logic             fifo_full,
    output logic [DAC_W-1:0] dac_word,
    output logic             sample_hold,
    output logic [DAC_W-2:0] res_data,
    output logic             res_push
);

    localparam int unsigned      RES_W = DAC_W - 1;
    localparam logic [DAC_W-1:0] MID   = {1'b1, {(DAC_W-1){1'b0}}};

    seq_state_e       state;
    logic             cmp_sync;
    logic             trial_last;
    logic             bit_last;
    logic [RES_W-1:0] sar_result;
    logic             conv_done;
    logic             start_conv;
    logic             step_trial;
    logic             run_dwell;

    // Control decode.
    always_comb begin
        run_dwell  = conv_en && (state == SEQ_CONV);
        step_trial = run_dwell && trial_last;
        conv_done  = step_trial && bit_last;
        start_conv = conv_en && ((state == SEQ_IDLE) || conv_done);
    end

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_above),
        .q_sync  (cmp_sync)
    );

    dsadc_dwell #(.DAC_W(DAC_W), .SET_W(SET_W)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!conv_en),
        .load  (start_conv),
        .run   (run_dwell),
        .mult  (settle_mult),
        .last  (trial_last)
    );

    dsadc_sar_reg #(.DAC_W(DAC_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!conv_en),
        .load     (start_conv),
        .step     (step_trial),
        .keep     (cmp_sync),
        .word     (dac_word),
        .last_bit (bit_last),
        .result   (sar_result)
    );

    // State, sample pulse, and result push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            sample_hold <= 1'b0;
            res_push    <= 1'b0;
            res_data    <= '0;
        end else begin
            sample_hold <= 1'b0;
            res_push    <= 1'b0;
            if (!conv_en) begin
                state <= SEQ_IDLE;
            end else begin
                if (start_conv) begin
                    state       <= SEQ_CONV;
                    sample_hold <= 1'b1;
                end
                if (conv_done && !fifo_full) begin
                    res_data <= sar_result;
                    res_push <= 1'b1;
                end
            end
        end
    end

    AST_START_MID: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> (dac_word == MID)); // R2
    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> !res_push); // R6
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> (dac_word == '0 && !sample_hold && !res_push)); // R7
    AST_PUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        res_push |-> sample_hold); // R3
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_push |-> $stable(res_data)); // R6

endmodule : dsadc_sar_seq

// File: tb/tb_dsadc_sar_seq.sv
module tb_dsadc_sar_seq;

    localparam int DAC_W = 5;
    localparam int SET_W = 4;
    localparam int BASE  = 1 << DAC_W;
    localparam int NVEC  = 8;

    // Stimulus and expected vectors: input code, settle value, expected result.
    localparam int VEC_VIN [NVEC] = '{0, 31, 16, 15, 20, 5, 1, 30};
    localparam int VEC_SET [NVEC] = '{0, 0, 1, 2, 0, 3, 0, 15};
    localparam int VEC_EXP [NVEC] = '{0, 15, 8, 7, 10, 2, 0, 15};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             conv_en = 1'b0;
    logic [SET_W-1:0] settle_mult = '0;
    logic             fifo_full = 1'b0;
    logic [DAC_W-1:0] dac_word;
    logic             sample_hold;
    logic [DAC_W-2:0] res_data;
    logic             res_push;
    int               vin = 0;
    logic             cmp_above;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Analog model: the input sits half a code above vin.
    assign cmp_above = (vin >= int'(dac_word));

    dsadc_sar_seq #(.DAC_W(DAC_W), .SET_W(SET_W)) dut (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .settle_mult(settle_mult),
        .cmp_above(cmp_above), .fifo_full(fifo_full), .dac_word(dac_word),
        .sample_hold(sample_hold), .res_data(res_data), .res_push(res_push)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_sample();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (sample_hold) return;
        end
        chk(1'b0, "R2 no sample pulse", 0, 1);
    endtask

    // Count cycles from the current sample cycle to the push; return the count.
    task automatic wait_push(output int n);
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            n = n + 1;
            if (res_push) return;
        end
    endtask

    initial begin
        int n;
        int t;
        repeat (3) @(negedge clk);
        chk(dac_word == 0, "R1 dac_word", int'(dac_word), 0);
        chk(!sample_hold && !res_push, "R1 strobes", int'(sample_hold) + int'(res_push), 0);
        rst_n = 1'b1;

        // Vector table walk: R2 R3 R4 R5.
        for (int v = 0; v < NVEC; v++) begin
            conv_en = 1'b0;
            @(negedge clk);
            vin = VEC_VIN[v];
            settle_mult = SET_W'(VEC_SET[v]);
            t = BASE * (VEC_SET[v] + 1);
            conv_en = 1'b1;
            wait_sample();
            chk(dac_word == 5'd16, "R2 mid-scale", int'(dac_word), 16);
            @(negedge clk);
            chk(!sample_hold, "R2 single pulse", int'(sample_hold), 0);
            repeat (t - 1) @(negedge clk);
            chk(int'(dac_word) == ((vin >= 16) ? 24 : 8), "R4 first step",
                int'(dac_word), (vin >= 16) ? 24 : 8);
            wait_push(n);
            chk(n == DAC_W * t - t, "R3 conversion length", n + t, DAC_W * t);
            chk(int'(res_data) == VEC_EXP[v], "R5 result", int'(res_data), VEC_EXP[v]);
            chk(sample_hold, "R3 back-to-back restart", int'(sample_hold), 1);
            conv_en = 1'b0;
            @(negedge clk);
            chk(dac_word == 0 && !sample_hold, "R7 idle after disable", int'(dac_word), 0);
        end

        // R6: full FIFO at the end of a conversion drops the result.
        vin = 9; settle_mult = '0; conv_en = 1'b1;
        wait_sample();
        fifo_full = 1'b1;
        n = 0;
        for (int i = 0; i < DAC_W * BASE; i++) begin
            @(negedge clk);
            if (res_push) n = n + 1;
        end
        chk(n == 0, "R6 no push when full", n, 0);
        chk(sample_hold, "R6 next conversion started", int'(sample_hold), 1);
        chk(res_data == 4'd15, "R6 data held", int'(res_data), 15);
        fifo_full = 1'b0;
        wait_push(n);
        chk(n == DAC_W * BASE, "R6 push resumes", n, DAC_W * BASE);
        chk(res_data == 4'd4, "R6 result after full", int'(res_data), 4);

        // R7: enable drops mid-trial.
        conv_en = 1'b0; @(negedge clk);
        vin = 25; conv_en = 1'b1;
        wait_sample();
        repeat (40) @(negedge clk);
        conv_en = 1'b0;
        @(negedge clk);
        chk(dac_word == 0, "R7 dac cleared", int'(dac_word), 0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (res_push || sample_hold) n = n + 1;
        end
        chk(n == 0, "R7 abandoned", n, 0);

        // R8: settle change during a conversion applies only to the next one.
        settle_mult = 4'd1; vin = 12; conv_en = 1'b1;
        wait_sample();
        settle_mult = 4'd7;
        wait_push(n);
        chk(n == DAC_W * BASE * 2, "R8 captured settle", n, DAC_W * BASE * 2);
        chk(res_data == 4'd6, "R5 result mid-range", int'(res_data), 6);
        wait_push(n);
        chk(n == DAC_W * BASE * 8, "R8 new settle applied", n, DAC_W * BASE * 8);

        // R1: reset during a conversion.
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_word == 0 && !res_push && !sample_hold, "R1 reset mid-run", int'(dac_word), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule : tb_dsadc_sar_seq